// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Almost Flags

This block buffers words between two unrelated clock domains. The producer side writes on its own clock. It has an active-low primary enable and an active-high secondary enable, and the secondary enable can be tied high when it is not needed. The consumer side reads on a separate clock. Both of its enables are active low, so that one can serve system control while the other serves steering logic. The depth is a power-of-two parameter. The data width defaults to 9 bits.

Four active-low status flags report fill state. Each flag belongs to the domain that acts on it. The empty flag and the almost-empty flag are registers clocked by the read clock. The full flag and the almost-full flag are registers clocked by the write clock. The almost thresholds are two offsets, n and m, held inside the block. An external offset register block loads them through a strobe in the domain that uses each one, and both offsets return to 7 on reset. Each pointer crosses to the other domain as a Gray code through two flip-flops. As a result a flag may release late but never early.

The read data sits in an output register. That register keeps the last word delivered while the FIFO is empty. An active-low output enable zeroes the visible data and the valid indication without touching the register.

Top module: `pflag_async_fifo`

## Requirements
- R1: A write is accepted on a rising `wr_clk` edge only if `wr_en_n` is 0, `wr_en2` is 1 and `full_n` is 1. With `wr_en2` at 0, or `wr_en_n` at 1, the edge stores nothing.
- R2: A read is accepted on a rising `rd_clk` edge only if `rd_en1_n` and `rd_en2_n` are both 0 and `empty_n` is 1. If the read is not accepted, `dout` keeps the last word read.
- R3: All four flags are active low. `empty_n` and `aempty_n` are registers clocked by `rd_clk`. `full_n` and `afull_n` are registers clocked by `wr_clk`.
- R4: Once the pointers have settled, `aempty_n` is 0 while the unread count is at most n, and 1 once the count is n+1 or more.
- R5: Once the pointers have settled, `afull_n` is 0 while the unread count is at least DEPTH-m, and 1 otherwise. `full_n` is 0 exactly at DEPTH words.
- R6: n and m are 7 after reset. A 1 on `ae_ld` at a `rd_clk` edge loads n from `ae_off`. A 1 on `af_ld` at a `wr_clk` edge loads m from `af_off`.
- R7: While `rst` is 1 at an edge of either clock, the FIFO empties and accepts neither reads nor writes. Afterwards `empty_n`=0, `aempty_n`=0, `full_n`=1, `afull_n`=1, the output register is 0 and `dvalid`=0.
- R8: Words leave in the order they were written. The first word is captured into `dout` by the first accepted read, which is the `rd_clk` edge after the one where `empty_n` rises.
- R9: A flag driven by the other domain's pointer never releases before the true count allows it. It settles within three edges of its own clock after the last pointer change.
- R10: While `oe_n` is 1, `dout` is 0 and `dvalid` is 0. The output register keeps its content, and it shows again when `oe_n` returns to 0. `dvalid` is 1 when `oe_n` is 0 and at least one read has been accepted since reset.
- R11: Writes attempted while full are dropped. The count stays at DEPTH, and the stored words stay intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst | input | 1 | Synchronous active-high reset, sampled by both clocks |
| wr_clk | input | 1 | Write clock |
| wr_en_n | input | 1 | Primary write enable, active low |
| wr_en2 | input | 1 | Secondary write enable, active high |
| din | input | W | Write data |
| af_ld | input | 1 | Loads m from af_off (write domain) |
| af_off | input | log2(DEPTH) | Almost-full offset m |
| full_n | output | 1 | Full flag, active low, write domain |
| afull_n | output | 1 | Almost-full flag, active low, write domain |
| rd_clk | input | 1 | Read clock |
| rd_en1_n | input | 1 | First read enable, active low |
| rd_en2_n | input | 1 | Second read enable, active low |
| ae_ld | input | 1 | Loads n from ae_off (read domain) |
| ae_off | input | log2(DEPTH) | Almost-empty offset n |
| oe_n | input | 1 | Output enable, active low |
| dout | output | W | Read data register, gated by oe_n |
| dvalid | output | 1 | Output holds a delivered word and is enabled |
| empty_n | output | 1 | Empty flag, active low, read domain |
| aempty_n | output | 1 | Almost-empty flag, active low, read domain |

## Verification
Read data is due on the read edge that accepts the read, so the bench samples it at the next falling read edge. Flags driven from the same domain update on the very next edge of that domain. Flags that depend on the other domain's pointer need up to three destination edges: two synchronizer stages and the flag register. The bench therefore waits eight edges of each clock before it compares any flag with the count it keeps itself. The "never early" rule (R9) is checked the other way round: the bench samples a flag within one destination edge of the stimulus that would release it, and it must still be asserted there.

// File: rtl/fifo_pf_pkg.sv
package fifo_pf_pkg;
  // Reset value of both almost-flag offsets.
  localparam int unsigned OFFSET_RESET = 7;

  // Pointer width: one wrap bit above the address bits.
  function automatic int ptr_bits(input int depth);
    return $clog2(depth) + 1;
  endfunction
endpackage

// File: rtl/fifo_pf_ram.sv
// Simple dual-port storage: write port on wclk, registered read port on rclk.
module fifo_pf_ram #(
  parameter int W  = 9,
  parameter int AW = 6
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic          rclk,
  input  logic          rrst,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  q
);
  localparam int WORDS = 1 << AW;

  logic [W-1:0] mem [WORDS];

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  // Output register doubles as the held-last-word register.
  always_ff @(posedge rclk) begin
    if (rrst)    q <= '0;
    else if (re) q <= mem[raddr];
  end
endmodule

// File: rtl/fifo_pf_xfer.sv
// Two-stage synchronizer for a Gray pointer, followed by Gray-to-binary decode.
module fifo_pf_xfer #(
  parameter int PW = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [PW-1:0] gray_in,
  output logic [PW-1:0] bin_out
);
  logic [PW-1:0] stage1, stage2;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= '0;
      stage2 <= '0;
    end else begin
      stage1 <= gray_in;
      stage2 <= stage1;
    end
  end

  always_comb begin
    bin_out[PW-1] = stage2[PW-1];
    for (int i = PW - 2; i >= 0; i--) begin
      bin_out[i] = bin_out[i+1] ^ stage2[i];
    end
  end
endmodule

// File: rtl/fifo_pf_wr.sv
// Write-domain control: pointer, full and almost-full flags, offset m.
module fifo_pf_wr import fifo_pf_pkg::*; #(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en_n,
  input  logic          en2,
  input  logic          m_ld,
  input  logic [AW-1:0] m_in,
  input  logic [AW:0]   rptr_bin,
  output logic [AW:0]   wptr_bin,
  output logic [AW:0]   wptr_gray,
  output logic          we,
  output logic          full_n,
  output logic          afull_n
);
  localparam int PW = AW + 1;
  localparam logic [PW-1:0] FULL_CNT = {1'b1, {AW{1'b0}}};

  logic [AW-1:0] m_q;
  logic [PW-1:0] bin_nxt, cnt_nxt, af_level;

  assign we       = ~rst & ~en_n & en2 & full_n;
  assign bin_nxt  = wptr_bin + {{(PW-1){1'b0}}, we};
  // Stale read pointer can only overstate the count: flags err on the safe side.
  assign cnt_nxt  = bin_nxt - rptr_bin;
  assign af_level = FULL_CNT - {1'b0, m_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr_bin  <= '0;
      wptr_gray <= '0;
      full_n    <= 1'b1;
      afull_n   <= 1'b1;
      m_q       <= AW'(OFFSET_RESET);
    end else begin
      wptr_bin  <= bin_nxt;
      wptr_gray <= bin_nxt ^ (bin_nxt >> 1);
      full_n    <= (cnt_nxt != FULL_CNT);
      afull_n   <= (cnt_nxt < af_level);
      if (m_ld) m_q <= m_in;
    end
  end
endmodule

// File: rtl/fifo_pf_rd.sv
// Read-domain control: pointer, empty and almost-empty flags, offset n.
module fifo_pf_rd import fifo_pf_pkg::*; #(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en1_n,
  input  logic          en2_n,
  input  logic          n_ld,
  input  logic [AW-1:0] n_in,
  input  logic [AW:0]   wptr_bin,
  output logic [AW:0]   rptr_bin,
  output logic [AW:0]   rptr_gray,
  output logic          re,
  output logic          empty_n,
  output logic          aempty_n,
  output logic          seen
);
  localparam int PW = AW + 1;

  logic [AW-1:0] n_q;
  logic [PW-1:0] bin_nxt, cnt_nxt;

  assign re      = ~rst & ~en1_n & ~en2_n & empty_n;
  assign bin_nxt = rptr_bin + {{(PW-1){1'b0}}, re};
  // Stale write pointer can only understate the count: flags err on the safe side.
  assign cnt_nxt = wptr_bin - bin_nxt;

  always_ff @(posedge clk) begin
    if (rst) begin
      rptr_bin  <= '0;
      rptr_gray <= '0;
      empty_n   <= 1'b0;
      aempty_n  <= 1'b0;
      seen      <= 1'b0;
      n_q       <= AW'(OFFSET_RESET);
    end else begin
      rptr_bin  <= bin_nxt;
      rptr_gray <= bin_nxt ^ (bin_nxt >> 1);
      empty_n   <= (cnt_nxt != '0);
      aempty_n  <= (cnt_nxt > {1'b0, n_q});
      if (re)   seen <= 1'b1;
      if (n_ld) n_q  <= n_in;
    end
  end
endmodule

// File: rtl/pflag_async_fifo.sv
module pflag_async_fifo import fifo_pf_pkg::*; #(
  parameter  int W     = 9,
  parameter  int DEPTH = 64,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic          rst,
  input  logic          wr_clk,
  input  logic          wr_en_n,
  input  logic          wr_en2,
  input  logic [W-1:0]  din,
  input  logic          af_ld,
  input  logic [AW-1:0] af_off,
  output logic          full_n,
  output logic          afull_n,
  input  logic          rd_clk,
  input  logic          rd_en1_n,
  input  logic          rd_en2_n,
  input  logic          ae_ld,
  input  logic [AW-1:0] ae_off,
  input  logic          oe_n,
  output logic [W-1:0]  dout,
  output logic          dvalid,
  output logic          empty_n,
  output logic          aempty_n
);
  localparam int PW = ptr_bits(DEPTH);

  logic [PW-1:0] wbin, wgray, rbin, rgray;
  logic [PW-1:0] wbin_at_rd, rbin_at_wr;
  logic          we, re, seen;
  logic [W-1:0]  q;

  fifo_pf_wr #(.AW(AW)) u_wr (
    .clk(wr_clk), .rst(rst), .en_n(wr_en_n), .en2(wr_en2),
    .m_ld(af_ld), .m_in(af_off), .rptr_bin(rbin_at_wr),
    .wptr_bin(wbin), .wptr_gray(wgray), .we(we),
    .full_n(full_n), .afull_n(afull_n)
  );

  fifo_pf_rd #(.AW(AW)) u_rd (
    .clk(rd_clk), .rst(rst), .en1_n(rd_en1_n), .en2_n(rd_en2_n),
    .n_ld(ae_ld), .n_in(ae_off), .wptr_bin(wbin_at_rd),
    .rptr_bin(rbin), .rptr_gray(rgray), .re(re),
    .empty_n(empty_n), .aempty_n(aempty_n), .seen(seen)
  );

  fifo_pf_xfer #(.PW(PW)) u_w2r (
    .clk(rd_clk), .rst(rst), .gray_in(wgray), .bin_out(wbin_at_rd)
  );

  fifo_pf_xfer #(.PW(PW)) u_r2w (
    .clk(wr_clk), .rst(rst), .gray_in(rgray), .bin_out(rbin_at_wr)
  );

  fifo_pf_ram #(.W(W), .AW(AW)) u_ram (
    .wclk(wr_clk), .we(we), .waddr(wbin[AW-1:0]), .wdata(din),
    .rclk(rd_clk), .rrst(rst), .re(re), .raddr(rbin[AW-1:0]), .q(q)
  );

  assign dout   = oe_n ? '0 : q;
  assign dvalid = ~oe_n & seen;
endmodule

// File: rtl/pflag_async_fifo_chk.sv
module pflag_async_fifo_chk #(
  parameter int W  = 9,
  parameter int AW = 6
) (
  input logic          rst,
  input logic          wr_clk,
  input logic          rd_clk,
  input logic          full_n,
  input logic          afull_n,
  input logic          empty_n,
  input logic          aempty_n,
  input logic [AW:0]   wbin,
  input logic [AW:0]   rbin,
  input logic [AW:0]   wbin_at_rd,
  input logic [AW:0]   rbin_at_wr,
  input logic [W-1:0]  q
);
  localparam int PW = AW + 1;
  localparam logic [PW-1:0] CAP = {1'b1, {AW{1'b0}}};

  // R11
  no_overflow_chk: assert property (@(posedge wr_clk) disable iff (rst)
    !full_n |=> $stable(wbin));

  // R2
  no_underflow_chk: assert property (@(posedge rd_clk) disable iff (rst)
    !empty_n |=> $stable(rbin));

  // R2
  hold_last_chk: assert property (@(posedge rd_clk) disable iff (rst)
    !empty_n |=> $stable(q));

  // R4
  aempty_covers_empty_chk: assert property (@(posedge rd_clk) disable iff (rst)
    !empty_n |-> !aempty_n);

  // R5
  afull_covers_full_chk: assert property (@(posedge wr_clk) disable iff (rst)
    !full_n |-> !afull_n);

  // R9
  rd_view_bound_chk: assert property (@(posedge rd_clk) disable iff (rst)
    (wbin_at_rd - rbin) <= CAP);

  // R9
  wr_view_bound_chk: assert property (@(posedge wr_clk) disable iff (rst)
    (wbin - rbin_at_wr) <= CAP);

  // R7
  reset_state_chk: assert property (@(posedge rd_clk)
    rst |=> (!empty_n && !aempty_n && q == '0));
endmodule

bind pflag_async_fifo pflag_async_fifo_chk #(.W(W), .AW(AW)) u_chk (
  .rst(rst), .wr_clk(wr_clk), .rd_clk(rd_clk),
  .full_n(full_n), .afull_n(afull_n), .empty_n(empty_n), .aempty_n(aempty_n),
  .wbin(wbin), .rbin(rbin), .wbin_at_rd(wbin_at_rd), .rbin_at_wr(rbin_at_wr),
  .q(q)
);

// File: tb/pflag_async_fifo_test.sv
`timescale 1ns/1ps
module pflag_async_fifo_test;
  localparam int W = 9, DEPTH = 16, AW = 4;

  logic rst = 1'b1, wr_clk = 1'b0, rd_clk = 1'b0;
  logic wr_en_n = 1'b1, wr_en2 = 1'b1, af_ld = 1'b0, ae_ld = 1'b0;
  logic rd_en1_n = 1'b1, rd_en2_n = 1'b1, oe_n = 1'b0;
  logic [W-1:0] din = '0;
  logic [AW-1:0] af_off = '0, ae_off = '0;
  logic full_n, afull_n, empty_n, aempty_n, dvalid;
  logic [W-1:0] dout;

  pflag_async_fifo #(.W(W), .DEPTH(DEPTH)) uut (
    .rst(rst), .wr_clk(wr_clk), .wr_en_n(wr_en_n), .wr_en2(wr_en2), .din(din),
    .af_ld(af_ld), .af_off(af_off), .full_n(full_n), .afull_n(afull_n),
    .rd_clk(rd_clk), .rd_en1_n(rd_en1_n), .rd_en2_n(rd_en2_n),
    .ae_ld(ae_ld), .ae_off(ae_off), .oe_n(oe_n),
    .dout(dout), .dvalid(dvalid), .empty_n(empty_n), .aempty_n(aempty_n)
  );

  always #2 wr_clk = ~wr_clk;                          // 250 MHz
  initial begin #0.25; forever #3.3 rd_clk = ~rd_clk; end

  int n_chk = 0, n_bad = 0, cur_n = 7, cur_m = 7;
  bit done = 1'b0;
  logic [W-1:0] model[$];
  logic [W-1:0] last_rd = '0;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic push(input logic [W-1:0] d);
    @(negedge wr_clk); wr_en_n = 1'b0; wr_en2 = 1'b1; din = d;
    @(negedge wr_clk); wr_en_n = 1'b1;
    if (model.size() < DEPTH) model.push_back(d);
  endtask

  task automatic pop(input string tag);
    @(negedge rd_clk); rd_en1_n = 1'b0; rd_en2_n = 1'b0;
    @(negedge rd_clk); rd_en1_n = 1'b1; rd_en2_n = 1'b1;
    if (model.size() > 0) begin
      last_rd = model.pop_front();
      chk({tag, " dvalid"}, int'(dvalid), 1);
    end
    chk({tag, " data"}, int'(dout), int'(last_rd));
  endtask

  task automatic settle();
    repeat (8) @(posedge rd_clk);
    repeat (8) @(posedge wr_clk);
    @(negedge rd_clk);
  endtask

  task automatic check_flags(input string tag);
    int c;
    c = model.size();
    chk({tag, " R3 R9 empty_n"}, int'(empty_n), int'(c != 0));
    chk({tag, " R4 aempty_n"}, int'(aempty_n), int'(c > cur_n));
    chk({tag, " R5 full_n"}, int'(full_n), int'(c != DEPTH));
    chk({tag, " R5 afull_n"}, int'(afull_n), int'(c < DEPTH - cur_m));
  endtask

  task automatic load_offs(input int n, input int m);
    @(negedge rd_clk); ae_off = AW'(n); ae_ld = 1'b1;
    @(negedge rd_clk); ae_ld = 1'b0;
    @(negedge wr_clk); af_off = AW'(m); af_ld = 1'b1;
    @(negedge wr_clk); af_ld = 1'b0;
    cur_n = n; cur_m = m;
  endtask

  initial begin
    repeat (4) @(posedge rd_clk);
    repeat (4) @(posedge wr_clk);
    @(negedge wr_clk); rst = 1'b0;
    settle();
    // R7 reset state
    chk("R7 empty_n", int'(empty_n), 0);
    chk("R7 aempty_n", int'(aempty_n), 0);
    chk("R7 full_n", int'(full_n), 1);
    chk("R7 afull_n", int'(afull_n), 1);
    chk("R7 dout", int'(dout), 0);
    chk("R7 dvalid", int'(dvalid), 0);

    // R1: each write enable alone stores nothing
    @(negedge wr_clk); wr_en_n = 1'b0; wr_en2 = 1'b0;
    repeat (3) @(negedge wr_clk);
    wr_en_n = 1'b1; wr_en2 = 1'b1;
    repeat (3) @(negedge wr_clk);
    settle();
    chk("R1 empty_n after blocked writes", int'(empty_n), 0);

    // R8: first word captured on the read edge after empty_n rises
    @(negedge rd_clk); rd_en1_n = 1'b0; rd_en2_n = 1'b0;
    push(9'h1A5);
    for (int i = 0; i < 20 && empty_n !== 1'b1; i++) @(negedge rd_clk);
    chk("R8 empty_n rose", int'(empty_n), 1);
    @(negedge rd_clk);
    last_rd = model.pop_front();
    chk("R8 first word", int'(dout), int'(last_rd));
    repeat (3) begin
      @(negedge rd_clk);
      chk("R2 held while empty", int'(dout), int'(last_rd));
    end
    chk("R2 empty_n after drain", int'(empty_n), 0);
    rd_en1_n = 1'b1; rd_en2_n = 1'b1;

    // R2: one read enable alone reads nothing
    push(9'h033); push(9'h0CC);
    settle();
    @(negedge rd_clk); rd_en1_n = 1'b0; rd_en2_n = 1'b1;
    repeat (3) @(negedge rd_clk);
    rd_en1_n = 1'b1; rd_en2_n = 1'b0;
    repeat (3) @(negedge rd_clk);
    rd_en2_n = 1'b1;
    chk("R2 dout unchanged", int'(dout), int'(last_rd));
    pop("R2 R8 order");
    pop("R2 R8 order");
    settle();
    check_flags("drained");

    // R9 not early: almost-empty must still be low just after count reaches n+1
    for (int i = 0; i < 8; i++) push(W'(i + 40));
    chk("R9 aempty_n not early", int'(aempty_n), 0);
    settle();
    chk("R4 R6 aempty_n default n", int'(aempty_n), 1);
    for (int i = 0; i < 8; i++) pop("R8 drain");
    settle();

    // R11 overfill, R9 full release not early
    for (int i = 0; i < DEPTH; i++) push(W'(300 + i * 3));
    settle();
    chk("R11 full_n at depth", int'(full_n), 0);
    for (int i = 0; i < 3; i++) push(9'h1FF);
    settle();
    chk("R11 full_n still low", int'(full_n), 0);
    pop("R11 first word");
    chk("R9 full_n not early", int'(full_n), 0);
    settle();
    chk("R11 full_n released", int'(full_n), 1);
    for (int i = 1; i < DEPTH; i++) pop("R11 words intact");
    settle();
    chk("R11 empty after drain", int'(empty_n), 0);

    // R10 output enable gating
    @(negedge rd_clk); oe_n = 1'b1; #1;
    chk("R10 dout gated", int'(dout), 0);
    chk("R10 dvalid gated", int'(dvalid), 0);
    @(negedge rd_clk); oe_n = 1'b0; #1;
    chk("R10 dout restored", int'(dout), int'(last_rd));
    chk("R10 dvalid restored", int'(dvalid), 1);

    // Sweep every fill level under several offset pairs (R4 R5 R6)
    for (int s = 0; s < 4; s++) begin
      case (s)
        1: load_offs(0, 0);
        2: load_offs(3, 12);
        3: load_offs(15, 15);
        default: ;
      endcase
      for (int k = 0; k <= DEPTH; k++) begin
        for (int i = 0; i < k; i++) push(W'((s * 61 + k * 7 + i * 13) & 511));
        settle();
        check_flags($sformatf("R6 sweep s=%0d k=%0d", s, k));
        for (int i = 0; i < k; i++) pop("R8 sweep order");
        settle();
        check_flags("sweep drained");
      end
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #700000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run did not complete actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule